// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of cache lines that have missed and whose fill has not yet come back from memory. Each entry holds one block address plus the identifiers and sizes of every request waiting on that line. A request to a line that already has an entry is merged into it, so only the first miss to a line sends a read downstream. That read is always widened to the full line size, and each waiting request keeps its own original size for the response.

Requests arrive with a block address, an identifier and a size. The block reports at once, in the same cycle, whether a live entry holds that line and whether the request is accepted. A request is accepted either by merging into a live entry that still has room, or by taking a free entry while the downstream miss queue has space. Any other request is refused and changes nothing. When a line returns, its entry hands back the waiting identifiers one per cycle, oldest first, and then becomes free.

Top module: `mshr_file`

## Requirements
- R1: During and right after reset, no entry is live: `req_hit`, `rel_valid` and `fill_err` are 0 and `fill_ready` is 1.
- R2: `req_hit` is 1 in the same cycle whenever a live entry that is not releasing holds `req_addr`, whether `req_valid` is high or not.
- R3: A valid request that hits an entry holding fewer than MAX_MERGE requests is accepted in the same cycle, is appended to that entry, and raises no `mq_push`.
- R4: A valid request that misses is accepted only if an entry is free and `mq_level` is below MQ_CAP. In that cycle `mq_push` is 1, `mq_addr` equals `req_addr` and `mq_size` equals LINE_BYTES.
- R5: A valid request that hits a full entry, or misses while no entry is free, or misses while `mq_level` is at least MQ_CAP, has `req_accept` 0 and `mq_push` 0. It leaves every entry unchanged, so a later fill of that line releases only the requests accepted before it.
- R6: A fill accepted for a live line makes `rel_valid` high from the next cycle for exactly as many cycles as the entry holds requests. Each cycle gives one identifier on `rel_id` and its original size on `rel_size`, in arrival order. The entry is then free, and a later probe of that line misses.
- R7: `fill_ready` is 0 while identifiers are being released, and a `fill_valid` seen in that time has no effect.
- R8: An accepted fill whose address matches no live entry raises `fill_err` for one cycle, starting the next cycle. It releases nothing.
- R9: An entry that is releasing does not match probes, so a request to that line gets `req_hit` 0 and is treated as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Block address of the request |
| req_id | input | ID_W | Identifier of the request |
| req_size | input | SIZE_W | Original size of the request in bytes |
| req_hit | output | 1 | A live, non-releasing entry holds `req_addr` |
| req_accept | output | 1 | Request taken (merge or allocate) |
| mq_level | input | $clog2(MQ_CAP+1) | Current occupancy of the downstream miss queue |
| mq_push | output | 1 | Push one line read into the miss queue |
| mq_addr | output | ADDR_W | Block address of the pushed read |
| mq_size | output | SIZE_W | Size of the pushed read, always LINE_BYTES |
| fill_valid | input | 1 | A line has returned from memory |
| fill_addr | input | ADDR_W | Block address of the returned line |
| fill_ready | output | 1 | A fill can be taken this cycle |
| rel_valid | output | 1 | A waiting request is released this cycle |
| rel_id | output | ID_W | Identifier being released |
| rel_size | output | SIZE_W | Original size of the released request |
| fill_err | output | 1 | The last accepted fill matched no entry |

## Verification
The checker watches, on every cycle, the rules that need only a short history. A push never happens on a hit or with the miss queue at capacity. A refused request never pushes. Fills are blocked while a release is running. An error pulse always follows an accepted fill and never comes with a release. Other properties need whole scenarios, and only the bench can show them. These are the order and sizes of released identifiers, that a refused request leaves the table truly unchanged, that a line is free again after its fill, that a releasing line does not match, and the exact acceptance boundary when the merge limit, the entry count and the queue level are swept.

// File: rtl/mshr_pkg.sv
// Shared definitions for the miss tracking table.
// Assumes nothing beyond standard SystemVerilog packages.
package mshr_pkg;

    // What happens to an incoming request this cycle
    typedef enum logic [1:0] {
        OUTC_REJECT = 2'd0,
        OUTC_MERGE  = 2'd1,
        OUTC_ALLOC  = 2'd2
    } req_outcome_e;

endpackage

// File: rtl/mshr_entry.sv
// One table entry: line address, valid/releasing flags, and the ordered
// list of waiting request identifiers with their original sizes.
// Assumes alloc_en and merge_en are never high while release_en is high,
// and merge_en is only raised while count < MAX_MERGE.
module mshr_entry #(
    parameter int ADDR_W    = 12,
    parameter int ID_W      = 4,
    parameter int SIZE_W    = 7,
    parameter int MAX_MERGE = 3,
    localparam int CNT_W    = $clog2(MAX_MERGE + 1),
    localparam int SLOT_W   = (MAX_MERGE > 1) ? $clog2(MAX_MERGE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic              merge_en,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [ID_W-1:0]   in_id,
    input  logic [SIZE_W-1:0] in_size,
    input  logic              drain_start,
    input  logic              release_en,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              valid,
    output logic              draining,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  count,
    output logic [ID_W-1:0]   rd_id,
    output logic [SIZE_W-1:0] rd_size
);

    logic [ID_W-1:0]   id_q   [MAX_MERGE];
    logic [SIZE_W-1:0] size_q [MAX_MERGE];

    // Control state: valid, releasing flag, address and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            draining <= 1'b0;
            addr     <= '0;
            count    <= '0;
        end else if (release_en) begin
            valid    <= 1'b0;
            draining <= 1'b0;
            count    <= '0;
        end else begin
            if (alloc_en) begin
                valid <= 1'b1;
                addr  <= in_addr;
                count <= CNT_W'(1);
            end
            if (merge_en) begin
                count <= count + CNT_W'(1);
            end
            if (drain_start) begin
                draining <= 1'b1;
            end
        end
    end

    // Per-slot storage of waiting identifiers and sizes
    for (genvar s = 0; s < MAX_MERGE; s++) begin : g_slot
        logic wr_here;
        assign wr_here = (alloc_en && (s == 0)) ||
                         (merge_en && (count == CNT_W'(s)));
        // Slot write on allocate (slot 0) or merge (next free slot)
        always_ff @(posedge clk) begin
            if (wr_here) begin
                id_q[s]   <= in_id;
                size_q[s] <= in_size;
            end
        end
    end

    // Read port used by the release sequencer
    always_comb begin
        rd_id   = id_q[rd_slot];
        rd_size = size_q[rd_slot];
    end

endmodule

// File: rtl/mshr_lookup.sv
// Associative compare of one key against all entries, plus the lowest
// free entry. Releasing entries neither match nor count as free.
// Assumes at most one matchable entry per address (kept by the top).
module mshr_lookup #(
    parameter int N_ENTRIES = 4,
    parameter int ADDR_W    = 12,
    parameter int MAX_MERGE = 3,
    localparam int CNT_W    = $clog2(MAX_MERGE + 1),
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [N_ENTRIES-1:0]             ent_valid,
    input  logic [N_ENTRIES-1:0]             ent_draining,
    input  logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_addr,
    input  logic [N_ENTRIES-1:0][CNT_W-1:0]  ent_count,
    input  logic [ADDR_W-1:0]                key,
    output logic                             hit,
    output logic [IDX_W-1:0]                 hit_idx,
    output logic                             hit_full,
    output logic                             free_any,
    output logic [IDX_W-1:0]                 free_idx
);

    logic [N_ENTRIES-1:0] match_vec;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
        assign match_vec[e] = ent_valid[e] && !ent_draining[e] &&
                              (ent_addr[e] == key);
    end

    // Encode the matching entry and its fullness
    always_comb begin
        hit      = |match_vec;
        hit_idx  = '0;
        hit_full = 1'b0;
        for (int e = 0; e < N_ENTRIES; e++) begin
            if (match_vec[e]) begin
                hit_idx  = IDX_W'(e);
                hit_full = (ent_count[e] == CNT_W'(MAX_MERGE));
            end
        end
    end

    // Pick the lowest-numbered unused entry
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int e = N_ENTRIES - 1; e >= 0; e--) begin
            if (!ent_valid[e]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(e);
            end
        end
    end

endmodule

// File: rtl/mshr_file.sv
// Miss tracking table: merges requests to lines already missing, allocates
// entries for new misses while the miss queue has room, and releases the
// waiting identifiers of a returning line one per cycle in arrival order.
// Assumes mq_level is the miss queue occupancy seen this cycle.
module mshr_file
    import mshr_pkg::*;
#(
    parameter int N_ENTRIES  = 4,
    parameter int MAX_MERGE  = 3,
    parameter int ADDR_W     = 12,
    parameter int ID_W       = 4,
    parameter int SIZE_W     = 7,
    parameter int LINE_BYTES = 64,
    parameter int MQ_CAP     = 4,
    localparam int LVL_W     = $clog2(MQ_CAP + 1),
    localparam int CNT_W     = $clog2(MAX_MERGE + 1),
    localparam int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int SLOT_W    = (MAX_MERGE > 1) ? $clog2(MAX_MERGE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    input  logic [SIZE_W-1:0] req_size,
    output logic              req_hit,
    output logic              req_accept,
    input  logic [LVL_W-1:0]  mq_level,
    output logic              mq_push,
    output logic [ADDR_W-1:0] mq_addr,
    output logic [SIZE_W-1:0] mq_size,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              fill_ready,
    output logic              rel_valid,
    output logic [ID_W-1:0]   rel_id,
    output logic [SIZE_W-1:0] rel_size,
    output logic              fill_err
);

    logic [N_ENTRIES-1:0]             ent_valid;
    logic [N_ENTRIES-1:0]             ent_draining;
    logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [N_ENTRIES-1:0][CNT_W-1:0]  ent_count;
    logic [N_ENTRIES-1:0][ID_W-1:0]   ent_rd_id;
    logic [N_ENTRIES-1:0][SIZE_W-1:0] ent_rd_size;

    logic             rq_hit, rq_full, rq_free;
    logic [IDX_W-1:0] rq_hit_idx, rq_free_idx;
    logic             fl_hit, fl_full_unused, fl_free_unused;
    logic [IDX_W-1:0] fl_hit_idx, fl_free_idx_unused;

    req_outcome_e     outcome;
    logic             drain_act;
    logic [IDX_W-1:0] drain_idx;
    logic [SLOT_W-1:0] drain_ptr;
    logic             drain_last;
    logic             fill_take;
    logic             fill_err_q;

    // Probe of the request address
    mshr_lookup #(
        .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .MAX_MERGE(MAX_MERGE)
    ) u_req_look (
        .ent_valid(ent_valid), .ent_draining(ent_draining),
        .ent_addr(ent_addr), .ent_count(ent_count), .key(req_addr),
        .hit(rq_hit), .hit_idx(rq_hit_idx), .hit_full(rq_full),
        .free_any(rq_free), .free_idx(rq_free_idx)
    );

    // Probe of the returning line address
    mshr_lookup #(
        .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .MAX_MERGE(MAX_MERGE)
    ) u_fill_look (
        .ent_valid(ent_valid), .ent_draining(ent_draining),
        .ent_addr(ent_addr), .ent_count(ent_count), .key(fill_addr),
        .hit(fl_hit), .hit_idx(fl_hit_idx), .hit_full(fl_full_unused),
        .free_any(fl_free_unused), .free_idx(fl_free_idx_unused)
    );

    // Decide merge, allocate or reject for the current request
    always_comb begin
        if (rq_hit) begin
            outcome = rq_full ? OUTC_REJECT : OUTC_MERGE;
        end else if (rq_free && (mq_level < LVL_W'(MQ_CAP))) begin
            outcome = OUTC_ALLOC;
        end else begin
            outcome = OUTC_REJECT;
        end
    end

    assign req_hit    = rq_hit;
    assign req_accept = req_valid && (outcome != OUTC_REJECT);
    assign mq_push    = req_valid && (outcome == OUTC_ALLOC);
    assign mq_addr    = req_addr;
    assign mq_size    = SIZE_W'(LINE_BYTES);

    assign fill_ready = !drain_act;
    assign fill_take  = fill_valid && fill_ready;
    assign drain_last = (CNT_W'(drain_ptr) + CNT_W'(1)) == ent_count[drain_idx];

    // Entry array with per-entry strobes
    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
        logic a_en, m_en, d_en, r_en;
        assign a_en = mq_push && (rq_free_idx == IDX_W'(e));
        assign m_en = req_valid && (outcome == OUTC_MERGE) &&
                      (rq_hit_idx == IDX_W'(e));
        assign d_en = fill_take && fl_hit && (fl_hit_idx == IDX_W'(e));
        assign r_en = drain_act && drain_last && (drain_idx == IDX_W'(e));

        mshr_entry #(
            .ADDR_W(ADDR_W), .ID_W(ID_W), .SIZE_W(SIZE_W),
            .MAX_MERGE(MAX_MERGE)
        ) u_entry (
            .clk(clk), .rst_n(rst_n),
            .alloc_en(a_en), .merge_en(m_en),
            .in_addr(req_addr), .in_id(req_id), .in_size(req_size),
            .drain_start(d_en), .release_en(r_en), .rd_slot(drain_ptr),
            .valid(ent_valid[e]), .draining(ent_draining[e]),
            .addr(ent_addr[e]), .count(ent_count[e]),
            .rd_id(ent_rd_id[e]), .rd_size(ent_rd_size[e])
        );
    end

    // Release sequencer: walks the slots of the filled entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_act <= 1'b0;
            drain_idx <= '0;
            drain_ptr <= '0;
        end else if (drain_act) begin
            if (drain_last) begin
                drain_act <= 1'b0;
                drain_ptr <= '0;
            end else begin
                drain_ptr <= drain_ptr + SLOT_W'(1);
            end
        end else if (fill_take && fl_hit) begin
            drain_act <= 1'b1;
            drain_idx <= fl_hit_idx;
            drain_ptr <= '0;
        end
    end

    // One-cycle flag for a fill that found no entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_err_q <= 1'b0;
        end else begin
            fill_err_q <= fill_take && !fl_hit;
        end
    end

    assign fill_err  = fill_err_q;
    assign rel_valid = drain_act;
    assign rel_id    = ent_rd_id[drain_idx];
    assign rel_size  = ent_rd_size[drain_idx];

endmodule

// File: rtl/mshr_file_chk.sv
// Cycle-level properties of the miss tracking table, bound to mshr_file.
// Assumes the synchronous active-low reset of the bound instance.
module mshr_file_chk #(
    parameter int ADDR_W = 12,
    parameter int SIZE_W = 7,
    parameter int MQ_CAP = 4,
    localparam int LVL_W = $clog2(MQ_CAP + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_hit,
    input logic             req_accept,
    input logic [LVL_W-1:0] mq_level,
    input logic             mq_push,
    input logic             fill_valid,
    input logic             fill_ready,
    input logic             rel_valid,
    input logic             fill_err
);

    // R3: a line already tracked never triggers another read
    assert_push_needs_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mq_push |-> !req_hit);

    // R4: a read is pushed only while the miss queue has room
    assert_push_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mq_push |-> (mq_level < LVL_W'(MQ_CAP)));

    // R5: a refused request sends nothing downstream
    assert_reject_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_accept) |-> !mq_push);

    // R7: no fill is taken while releasing
    assert_release_blocks_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> !fill_ready);

    // R8: the error pulse follows an accepted fill
    assert_err_after_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_err |-> $past(fill_valid && fill_ready));

    // R8: an unmatched fill releases nothing
    assert_err_no_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_err |-> !rel_valid);

endmodule

bind mshr_file mshr_file_chk #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MQ_CAP(MQ_CAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
    .req_accept(req_accept), .mq_level(mq_level), .mq_push(mq_push),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .rel_valid(rel_valid), .fill_err(fill_err)
);

// File: tb/mshr_file_bench.sv
// Scenario sweep over the default configuration (4 entries, 3 merges,
// miss queue capacity 4, 64-byte lines).
module mshr_file_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_ENT  = 4;
    localparam int N_MRG  = 3;
    localparam int CAP    = 4;
    localparam int LINE   = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_id = '0;
    logic [6:0]  req_size = '0;
    logic        req_hit, req_accept;
    logic [2:0]  mq_level = '0;
    logic        mq_push;
    logic [11:0] mq_addr;
    logic [6:0]  mq_size;
    logic        fill_valid = 1'b0;
    logic [11:0] fill_addr = '0;
    logic        fill_ready, rel_valid, fill_err;
    logic [3:0]  rel_id;
    logic [6:0]  rel_size;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mshr_file u_mshr_file (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_id(req_id),
        .req_size(req_size), .req_hit(req_hit), .req_accept(req_accept),
        .mq_level(mq_level), .mq_push(mq_push), .mq_addr(mq_addr),
        .mq_size(mq_size), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_ready(fill_ready), .rel_valid(rel_valid), .rel_id(rel_id),
        .rel_size(rel_size), .fill_err(fill_err)
    );

    function automatic logic [11:0] line_of(input int k);
        return 12'(16'h040 + k * 12'h013);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance one edge and settle past it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_req(input int k, input int id, input int sz, input int lvl);
        req_valid = 1'b1;
        req_addr  = line_of(k);
        req_id    = 4'(id);
        req_size  = 7'(sz);
        mq_level  = 3'(lvl);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        req_addr = line_of(0);
        repeat (3) tick();
        // R1: reset state
        chk("R1 req_hit", int'(req_hit), 0);
        chk("R1 rel_valid", int'(rel_valid), 0);
        chk("R1 fill_err", int'(fill_err), 0);
        chk("R1 fill_ready", int'(fill_ready), 1);
        rst_n = 1'b1;
        tick();
        chk("R1 after release req_hit", int'(req_hit), 0);

        // R4: fill every entry with a distinct line, queue level below cap
        for (int e = 0; e < N_ENT; e++) begin
            drive_req(e, e, 4 + e, e % CAP);
            chk("R4 miss hit", int'(req_hit), 0);
            chk("R4 accept", int'(req_accept), 1);
            chk("R4 push", int'(mq_push), 1);
            chk("R4 mq_addr", int'(mq_addr), int'(line_of(e)));
            chk("R4 mq_size", int'(mq_size), LINE);
            tick();
        end
        req_valid = 1'b0;
        // R2: every allocated line now probes as a hit, even without req_valid
        for (int e = 0; e < N_ENT; e++) begin
            req_addr = line_of(e);
            #1;
            chk("R2 probe hit", int'(req_hit), 1);
        end

        // R5: new line with no free entry is refused
        drive_req(9, 15, 8, 0);
        chk("R5 no free accept", int'(req_accept), 0);
        chk("R5 no free push", int'(mq_push), 0);
        tick();

        // R3: merge up to the limit into line 0
        for (int m = 1; m < N_MRG; m++) begin
            drive_req(0, 7 + m, 9 + m, CAP);
            chk("R3 merge hit", int'(req_hit), 1);
            chk("R3 merge accept", int'(req_accept), 1);
            chk("R3 merge push", int'(mq_push), 0);
            tick();
        end
        // R5: one more merge exceeds the limit
        drive_req(0, 13, 30, 0);
        chk("R5 full merge accept", int'(req_accept), 0);
        chk("R5 full merge push", int'(mq_push), 0);
        tick();
        req_valid = 1'b0;

        // R6/R7: fill line 0; expected ids 0,8,9 sizes 4,10,11
        fill_valid = 1'b1;
        fill_addr  = line_of(0);
        #1;
        chk("R7 ready before fill", int'(fill_ready), 1);
        tick();
        fill_addr = line_of(1);  // R7: this fill must be ignored
        for (int k = 0; k < N_MRG; k++) begin
            chk("R6 rel_valid", int'(rel_valid), 1);
            chk("R6 rel_id", int'(rel_id), (k == 0) ? 0 : 7 + k);
            chk("R6 rel_size", int'(rel_size), (k == 0) ? 4 : 9 + k);
            chk("R7 ready low", int'(fill_ready), 0);
            if (k == N_MRG - 1) fill_valid = 1'b0;
            tick();
        end
        chk("R6 release done", int'(rel_valid), 0);
        chk("R7 ready back", int'(fill_ready), 1);
        req_addr = line_of(0);
        #1;
        chk("R6 line freed", int'(req_hit), 0);
        req_addr = line_of(1);
        #1;
        chk("R7 ignored fill kept line", int'(req_hit), 1);

        // R4/R5: queue level sweep with one free entry
        drive_req(5, 3, 6, CAP);
        chk("R5 queue full accept", int'(req_accept), 0);
        chk("R5 queue full push", int'(mq_push), 0);
        tick();
        drive_req(5, 3, 6, CAP - 1);
        chk("R4 queue room accept", int'(req_accept), 1);
        chk("R4 queue room push", int'(mq_push), 1);
        tick();
        req_valid = 1'b0;

        // R8: fill for an unknown line
        fill_valid = 1'b1;
        fill_addr  = line_of(12);
        tick();
        fill_valid = 1'b0;
        chk("R8 fill_err", int'(fill_err), 1);
        chk("R8 no release", int'(rel_valid), 0);
        tick();
        chk("R8 pulse ends", int'(fill_err), 0);

        // R9: merge into line 1, then fill it and probe it mid-release
        drive_req(1, 11, 20, 0);
        chk("R3 merge line1", int'(req_accept), 1);
        tick();
        req_valid  = 1'b0;
        fill_valid = 1'b1;
        fill_addr  = line_of(1);
        tick();
        fill_valid = 1'b0;
        chk("R6 line1 first id", int'(rel_id), 1);
        chk("R6 line1 first size", int'(rel_size), 5);
        drive_req(1, 14, 9, 0);
        chk("R9 releasing not hit", int'(req_hit), 0);
        chk("R5 no free during release", int'(req_accept), 0);
        tick();
        req_valid = 1'b0;
        chk("R6 line1 second id", int'(rel_id), 11);
        chk("R6 line1 second size", int'(rel_size), 20);
        tick();
        chk("R6 line1 done", int'(rel_valid), 0);
        drive_req(1, 14, 9, 0);
        chk("R4 realloc push", int'(mq_push), 1);
        tick();
        req_valid = 1'b0;
        #1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule